// File: doc/BRIEF.md
# Platform Interrupt Controller with Claim/Complete Contexts

This block collects a set of level-sensitive interrupt sources and presents them to a small number of targets, called contexts. Software reaches it over a plain 32-bit register bus. It programs a priority for every source, a set of enable bits and a threshold for every context, and handles interrupts through one claim/complete register per context. Each context has one interrupt output. That output is high while at least one source qualifies for the context. A source qualifies when its line is high, it is not currently claimed, it is enabled for the context, and its priority is strictly above the context threshold.

A handler reads the claim register of its context. The read returns the number of the best qualifying source and takes that source out of contention for every context. The handler services the source and then writes the same number back to the claim register. After that write the source competes again if its line is still high. Software empties a context by reading claim repeatedly until it returns 0. Source number 0 is reserved. It never interrupts, and a claim result of 0 means that nothing qualifies.

The default configuration has 32 source numbers (1 to 31 are usable), two contexts and 3-bit priorities.

Top module: `irqc_top`

## Requirements
- R1: After reset, every priority, enable word, threshold and claim register reads 0, and every interrupt output is low.
- R2: The priority of source n is at byte address 4*n and keeps the low 3 bits of the write data. Writes to the priority of source 0 have no effect, and it always reads 0.
- R3: The enables of context c start at byte address 0x2000 + 0x80*c. Source n is bit (n mod 32) of word (n div 32) in that range. Bit 0 of word 0 stays 0 whatever is written.
- R4: The control page of context c starts at 0x200000 + 0x1000*c. The threshold sits at page offset 0 and keeps the low 3 bits of the write data. Claim/complete sits at page offset 4.
- R5: Interrupt output c is high exactly when some source n ≥ 1 has its line high, is unclaimed, is enabled for c, and has a priority strictly greater than the threshold of c. The output follows the source lines with no clock delay.
- R6: A claim read returns the qualifying source with the highest priority, and the lowest number among equal priorities. It returns 0 when no source qualifies.
- R7: A claim read that returns n ≠ 0 removes source n from contention in every context until n is completed.
- R8: Writing a claimed number n to any claim register releases n. If its line is still high, n becomes deliverable again.
- R9: A completion write of 0, of a number that is not claimed, or of a value ≥ 32 is ignored.
- R10: Read data appears on the clock edge after the read strobe. Addresses that map to no register read 0 and ignore writes. This includes unaligned addresses, absent contexts, absent enable words and unused page offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 32 | Level interrupt lines, bit n is source n (bit 0 unused) |
| addr_i | input | 22 | Byte address of the register access |
| wdata_i | input | 32 | Write data |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| rdata_o | output | 32 | Read data, valid the cycle after rd_en_i |
| irq_o | output | 2 | One interrupt-pending output per context |

## Verification
The assertions assume that the bus never raises the read strobe and the write strobe in the same cycle. Under that assumption, a claim and a completion can never meet on the same source in the same cycle, and the claimed-state rules rely on this. They also assume that source lines change only between clock edges. The stimulus issues every access on its own with a gap cycle and changes source lines only on the falling clock edge, so it stays within both assumptions.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned ADDR_W = 22;

  localparam logic [ADDR_W-1:0] PRIO_END  = 22'h001000;
  localparam logic [ADDR_W-1:0] EN_BASE   = 22'h002000;
  localparam logic [ADDR_W-1:0] CTRL_BASE = 22'h200000;
  localparam logic [11:0]       OFF_THR   = 12'h000;
  localparam logic [11:0]       OFF_CLM   = 12'h004;

  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_PRIO = 2'd1,
    RG_ENAB = 2'd2,
    RG_CTRL = 2'd3
  } rgn_e;

  typedef struct packed {
    rgn_e        rgn;
    logic [9:0]  idx;
    logic [4:0]  word;
    logic [11:0] off;
  } dec_t;

  function automatic dec_t addr_decode(input logic [ADDR_W-1:0] a);
    dec_t              d;
    logic [ADDR_W-1:0] rel;
    d   = '0;
    rel = a - EN_BASE;
    if (a[1:0] != 2'b00) begin
      d.rgn = RG_NONE;
    end else if (a < PRIO_END) begin
      d.rgn = RG_PRIO;
      d.idx = a[11:2];
    end else if ((a >= EN_BASE) && (a < CTRL_BASE)) begin
      if (rel[20:17] == 4'd0) begin
        d.rgn  = RG_ENAB;
        d.idx  = rel[16:7];
        d.word = rel[6:2];
      end
    end else if (a >= CTRL_BASE) begin
      d.rgn = RG_CTRL;
      d.idx = {1'b0, a[20:12]};
      d.off = a[11:0];
    end
    return d;
  endfunction

endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  assign sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/irqc_cfg.sv
module irqc_cfg #(
  parameter int unsigned NSRC = 32,
  parameter int unsigned NCTX = 2,
  parameter int unsigned PW   = 3,
  localparam int unsigned IDW   = $clog2(NSRC),
  localparam int unsigned CTXW  = (NCTX > 1) ? $clog2(NCTX) : 1,
  localparam int unsigned NWORD = (NSRC + 31) / 32,
  localparam int unsigned WW    = (NWORD > 1) ? $clog2(NWORD) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 prio_we_i,
  input  logic                 en_we_i,
  input  logic                 thr_we_i,
  input  logic [IDW-1:0]       sel_src_i,
  input  logic [CTXW-1:0]      sel_ctx_i,
  input  logic [WW-1:0]        sel_word_i,
  input  logic [31:0]          wdata_i,
  output logic [NSRC*PW-1:0]   prio_o,
  output logic [NCTX*NSRC-1:0] en_o,
  output logic [NCTX*PW-1:0]   thr_o
);

  // priority per source, source 0 tied to zero
  for (genvar s = 0; s < NSRC; s++) begin : g_prio
    if (s == 0) begin : g_zero
      assign prio_o[0 +: PW] = '0;
    end else begin : g_reg
      logic [PW-1:0] p_q, p_d;
      logic          p_ce;
      assign p_ce = prio_we_i && (sel_src_i == IDW'(s));
      assign p_d  = wdata_i[PW-1:0];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   p_q <= '0;
        else if (p_ce) p_q <= p_d;
      end
      assign prio_o[s*PW +: PW] = p_q;
    end
  end

  // enable bits per context and source, bit for source 0 tied to zero
  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    for (genvar s = 0; s < NSRC; s++) begin : g_en
      if (s == 0) begin : g_zero
        assign en_o[c*NSRC] = 1'b0;
      end else begin : g_reg
        logic e_q, e_d, e_ce;
        assign e_ce = en_we_i && (sel_ctx_i == CTXW'(c)) &&
                      (sel_word_i == WW'(s / 32));
        assign e_d  = wdata_i[s % 32];
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)   e_q <= 1'b0;
          else if (e_ce) e_q <= e_d;
        end
        assign en_o[c*NSRC + s] = e_q;
      end
    end

    logic [PW-1:0] t_q, t_d;
    logic          t_ce;
    assign t_ce = thr_we_i && (sel_ctx_i == CTXW'(c));
    assign t_d  = wdata_i[PW-1:0];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   t_q <= '0;
      else if (t_ce) t_q <= t_d;
    end
    assign thr_o[c*PW +: PW] = t_q;
  end

endmodule

// File: rtl/irqc_gate.sv
module irqc_gate #(
  parameter int unsigned NSRC = 32,
  localparam int unsigned IDW = $clog2(NSRC)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic            claim_vld_i,
  input  logic [IDW-1:0]  claim_id_i,
  input  logic            cmpl_vld_i,
  input  logic [IDW-1:0]  cmpl_id_i,
  output logic [NSRC-1:0] pend_o
);

  logic [NSRC-1:0] claimed_q, claimed_d;

  always_comb begin
    claimed_d = claimed_q;
    if (cmpl_vld_i && (cmpl_id_i != '0)) claimed_d[cmpl_id_i] = 1'b0;
    if (claim_vld_i && (claim_id_i != '0)) claimed_d[claim_id_i] = 1'b1;
    claimed_d[0] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) claimed_q <= '0;
    else         claimed_q <= claimed_d;
  end

  assign pend_o = src_i & ~claimed_q & {{(NSRC-1){1'b1}}, 1'b0};

  AST_CLAIM_FRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_vld_i && (claim_id_i != '0)) |-> !claimed_q[claim_id_i]); // R7

  AST_CLAIM_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_vld_i && (claim_id_i != '0)) |=> !pend_o[$past(claim_id_i)]); // R7

  AST_CMPL_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_vld_i && (cmpl_id_i != '0) && !claim_vld_i) |=> (pend_o[$past(cmpl_id_i)] == src_i[$past(cmpl_id_i)])); // R8

  AST_ID0_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_o[0]); // R5

endmodule

// File: rtl/irqc_target.sv
module irqc_target #(
  parameter int unsigned NSRC = 32,
  parameter int unsigned PW   = 3,
  localparam int unsigned IDW = $clog2(NSRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NSRC-1:0]    pend_i,
  input  logic [NSRC-1:0]    en_i,
  input  logic [NSRC*PW-1:0] prio_i,
  input  logic [PW-1:0]      thr_i,
  output logic [IDW-1:0]     win_o,
  output logic               irq_o
);

  logic [NSRC-1:0] elig;

  for (genvar s = 0; s < NSRC; s++) begin : g_elig
    if (s == 0) begin : g_zero
      assign elig[0] = 1'b0;
    end else begin : g_cmp
      assign elig[s] = pend_i[s] && en_i[s] && (prio_i[s*PW +: PW] > thr_i);
    end
  end

  // highest priority wins, strict compare keeps the lowest id on ties
  always_comb begin
    logic [PW-1:0] best_p;
    logic          found;
    best_p = '0;
    found  = 1'b0;
    win_o  = '0;
    for (int s = 1; s < NSRC; s++) begin
      if (elig[s] && (!found || (prio_i[s*PW +: PW] > best_p))) begin
        found  = 1'b1;
        best_p = prio_i[s*PW +: PW];
        win_o  = IDW'(s);
      end
    end
  end

  assign irq_o = |elig;

  AST_IRQ_WINNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (win_o != '0)); // R5

  AST_WIN_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_o != '0) |-> (pend_i[win_o] && en_i[win_o] && (prio_i[win_o*PW +: PW] > thr_i))); // R6

endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int unsigned NSRC = 32,
  parameter int unsigned NCTX = 2,
  parameter int unsigned PW   = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NSRC-1:0]            src_i,
  input  logic [irqc_pkg::ADDR_W-1:0] addr_i,
  input  logic [31:0]                wdata_i,
  input  logic                       wr_en_i,
  input  logic                       rd_en_i,
  output logic [31:0]                rdata_o,
  output logic [NCTX-1:0]            irq_o
);
  import irqc_pkg::*;

  localparam int unsigned IDW   = $clog2(NSRC);
  localparam int unsigned CTXW  = (NCTX > 1) ? $clog2(NCTX) : 1;
  localparam int unsigned NWORD = (NSRC + 31) / 32;
  localparam int unsigned WW    = (NWORD > 1) ? $clog2(NWORD) : 1;
  localparam logic [9:0]  NSRC_L  = 10'(NSRC);
  localparam logic [9:0]  NCTX_L  = 10'(NCTX);
  localparam logic [4:0]  NWORD_L = 5'(NWORD);

  logic                 rst_n;
  dec_t                 dec;
  logic                 prio_ok, en_ok, thr_ok, clm_ok;
  logic [IDW-1:0]       sel_src;
  logic [CTXW-1:0]      sel_ctx;
  logic [WW-1:0]        sel_word;
  logic [NSRC*PW-1:0]   prio_flat;
  logic [NCTX*NSRC-1:0] en_flat;
  logic [NCTX*PW-1:0]   thr_flat;
  logic [NCTX*IDW-1:0]  win_flat;
  logic [NSRC-1:0]      pend;
  logic                 claim_vld, cmpl_vld;
  logic [IDW-1:0]       claim_id;
  logic [31:0]          rdata_q, rdata_d;

  irqc_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  assign dec      = addr_decode(addr_i);
  assign prio_ok  = (dec.rgn == RG_PRIO) && (dec.idx < NSRC_L) && (dec.idx != '0);
  assign en_ok    = (dec.rgn == RG_ENAB) && (dec.idx < NCTX_L) && (dec.word < NWORD_L);
  assign thr_ok   = (dec.rgn == RG_CTRL) && (dec.idx < NCTX_L) && (dec.off == OFF_THR);
  assign clm_ok   = (dec.rgn == RG_CTRL) && (dec.idx < NCTX_L) && (dec.off == OFF_CLM);
  assign sel_src  = dec.idx[IDW-1:0];
  assign sel_ctx  = dec.idx[CTXW-1:0];
  assign sel_word = dec.word[WW-1:0];

  irqc_cfg #(.NSRC(NSRC), .NCTX(NCTX), .PW(PW)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .prio_we_i  (wr_en_i && prio_ok),
    .en_we_i    (wr_en_i && en_ok),
    .thr_we_i   (wr_en_i && thr_ok),
    .sel_src_i  (sel_src),
    .sel_ctx_i  (sel_ctx),
    .sel_word_i (sel_word),
    .wdata_i    (wdata_i),
    .prio_o     (prio_flat),
    .en_o       (en_flat),
    .thr_o      (thr_flat)
  );

  assign claim_vld = rd_en_i && clm_ok;
  assign claim_id  = win_flat[sel_ctx*IDW +: IDW];
  assign cmpl_vld  = wr_en_i && clm_ok && (wdata_i < 32'(NSRC)) && (wdata_i != 32'd0);

  irqc_gate #(.NSRC(NSRC)) u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .src_i       (src_i),
    .claim_vld_i (claim_vld),
    .claim_id_i  (claim_id),
    .cmpl_vld_i  (cmpl_vld),
    .cmpl_id_i   (wdata_i[IDW-1:0]),
    .pend_o      (pend)
  );

  for (genvar c = 0; c < NCTX; c++) begin : g_tgt
    irqc_target #(.NSRC(NSRC), .PW(PW)) u_tgt (
      .clk_i  (clk_i),
      .rst_ni (rst_n),
      .pend_i (pend),
      .en_i   (en_flat[c*NSRC +: NSRC]),
      .prio_i (prio_flat),
      .thr_i  (thr_flat[c*PW +: PW]),
      .win_o  (win_flat[c*IDW +: IDW]),
      .irq_o  (irq_o[c])
    );
  end

  always_comb begin
    rdata_d = '0;
    if (prio_ok) begin
      rdata_d[PW-1:0] = prio_flat[sel_src*PW +: PW];
    end else if (en_ok) begin
      for (int b = 0; b < 32; b++) begin
        if ((int'(sel_word) * 32 + b) < int'(NSRC)) begin
          rdata_d[b] = en_flat[int'(sel_ctx) * int'(NSRC) + int'(sel_word) * 32 + b];
        end
      end
    end else if (thr_ok) begin
      rdata_d[PW-1:0] = thr_flat[sel_ctx*PW +: PW];
    end else if (clm_ok) begin
      rdata_d[IDW-1:0] = claim_id;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  AST_BUS_ONE_OP: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(rd_en_i && wr_en_i)); // R10

  AST_CLAIM_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n)
    (claim_vld && !irq_o[sel_ctx]) |=> (rdata_o == 32'd0)); // R6

endmodule

// File: tb/irqc_top_tb_top.sv
module irqc_top_tb_top;

  localparam int NSRC = 32;
  localparam int NCTX = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [31:0]     src;
  logic [21:0]     addr;
  logic [31:0]     wdata;
  logic            wr_en, rd_en;
  logic [31:0]     rdata;
  logic [NCTX-1:0] irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int prio_m [NSRC];
  bit en_m   [NCTX][NSRC];
  int thr_m  [NCTX];
  bit clm_m  [NSRC];

  always #2 clk = ~clk;

  irqc_top #(.NSRC(NSRC), .NCTX(NCTX), .PW(3)) dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .src_i   (src),
    .addr_i  (addr),
    .wdata_i (wdata),
    .wr_en_i (wr_en),
    .rd_en_i (rd_en),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  function automatic logic [21:0] pa(int s);       return 22'(4 * s); endfunction
  function automatic logic [21:0] ea(int c, int w); return 22'(32'h2000 + 32'h80 * c + 4 * w); endfunction
  function automatic logic [21:0] ta(int c);       return 22'(32'h200000 + 32'h1000 * c); endfunction
  function automatic logic [21:0] ca(int c);       return 22'(32'h200000 + 32'h1000 * c + 4); endfunction

  function automatic int model_win(int c);
    int best = 0;
    int bp   = -1;
    for (int i = 1; i < NSRC; i++) begin
      if (src[i] && !clm_m[i] && en_m[c][i] && (prio_m[i] > thr_m[c]) && (prio_m[i] > bp)) begin
        best = i;
        bp   = prio_m[i];
      end
    end
    return best;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [21:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [21:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic check_irqs(input string req);
    #1;
    for (int c = 0; c < NCTX; c++) check(req, 32'(irq[c]), 32'(model_win(c) != 0));
  endtask

  task automatic set_thr(input int c, input int v);
    wr(ta(c), 32'(v));
    thr_m[c] = v & 7;
  endtask

  // claim until 0, then complete every claimed id
  task automatic drain(input int c, input string req);
    int ids [$];
    logic [31:0] d;
    int exp;
    for (int n = 0; n < 40; n++) begin
      exp = model_win(c);
      rd(ca(c), d);
      check(req, d, 32'(exp));
      if (exp == 0) break;
      clm_m[exp] = 1'b1;
      ids.push_back(exp);
      check_irqs("R7 after claim");
    end
    foreach (ids[k]) begin
      wr(ca(c), 32'(ids[k]));
      clm_m[ids[k]] = 1'b0;
      check_irqs("R8 after complete");
    end
  endtask

  initial begin
    logic [31:0] d;
    logic [31:0] pat;
    rst_n = 1'b0; src = '0; addr = '0; wdata = '0; wr_en = 1'b0; rd_en = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      prio_m[i] = 0; clm_m[i] = 0;
      for (int c = 0; c < NCTX; c++) en_m[c][i] = 0;
    end
    for (int c = 0; c < NCTX; c++) thr_m[c] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    #1;
    check("R1 irq", 32'(irq), 32'd0);
    for (int s = 0; s < NSRC; s++) begin rd(pa(s), d); check("R1 prio", d, 32'd0); end
    for (int c = 0; c < NCTX; c++) begin
      rd(ea(c, 0), d); check("R1 enable", d, 32'd0);
      rd(ta(c), d);    check("R1 threshold", d, 32'd0);
      rd(ca(c), d);    check("R1 claim", d, 32'd0);
    end

    // R2 priority write / readback, upper bits dropped, source 0 fixed
    for (int s = 0; s < NSRC; s++) begin
      wr(pa(s), 32'h5A5A_5A50 | 32'((s * 3) % 8));
      prio_m[s] = (s == 0) ? 0 : (s * 3) % 8;
    end
    for (int s = 0; s < NSRC; s++) begin rd(pa(s), d); check("R2 prio readback", d, 32'(prio_m[s])); end

    // R3 enable words, bit 0 forced low
    wr(ea(0, 0), 32'hFFFF_FFFF);
    wr(ea(1, 0), 32'h9C3A_6E55);
    for (int i = 1; i < NSRC; i++) begin
      en_m[0][i] = 1'b1;
      en_m[1][i] = ((32'h9C3A_6E55 >> i) & 1) != 0;
    end
    rd(ea(0, 0), d); check("R3 enable ctx0", d, 32'hFFFF_FFFE);
    rd(ea(1, 0), d); check("R3 enable ctx1", d, 32'h9C3A_6E54);

    // R4 thresholds
    set_thr(0, 2);
    set_thr(1, 32'hF8);
    rd(ta(0), d); check("R4 threshold ctx0", d, 32'd2);
    rd(ta(1), d); check("R4 threshold ctx1", d, 32'd0);

    // R4 strict greater-than: source 3 alone
    @(negedge clk); src = 32'h0000_0008;
    wr(pa(3), 32'd4); prio_m[3] = 4;
    set_thr(0, 4);
    #1; check("R4 prio equal threshold", 32'(irq[0]), 32'd0);
    set_thr(0, 3);
    #1; check("R4 prio above threshold", 32'(irq[0]), 32'd1);

    // R5 R6 R7 R8 sweep over source patterns and thresholds
    for (int k = 0; k < 16; k++) begin
      pat = (k == 0) ? 32'd0 : ((32'(k + 1) * 32'h9E37_79B9) ^ (32'hF0F0_1234 >> k));
      set_thr(0, k % 4);
      set_thr(1, (k * 3) % 5);
      @(negedge clk); src = pat;
      check_irqs("R5 sweep");
      drain(k % 2, "R6 sweep claim");
      check_irqs("R8 sweep end");
    end

    // R6 ties resolved to lowest number
    set_thr(0, 0);
    wr(pa(5), 32'd7);  prio_m[5]  = 7;
    wr(pa(9), 32'd7);  prio_m[9]  = 7;
    wr(pa(13), 32'd7); prio_m[13] = 7;
    @(negedge clk); src = (32'd1 << 5) | (32'd1 << 9) | (32'd1 << 13);
    rd(ca(0), d); check("R6 tie first", d, 32'd5);  clm_m[5] = 1;
    rd(ca(0), d); check("R6 tie second", d, 32'd9); clm_m[9] = 1;
    rd(ca(0), d); check("R6 tie third", d, 32'd13); clm_m[13] = 1;
    rd(ca(0), d); check("R6 tie empty", d, 32'd0);
    for (int s = 5; s <= 13; s += 4) begin wr(ca(0), 32'(s)); clm_m[s] = 0; end

    // R7 claim in one context hides the source from the other
    wr(ea(1, 0), 32'hFFFF_FFFF);
    for (int i = 1; i < NSRC; i++) en_m[1][i] = 1'b1;
    set_thr(1, 0);
    @(negedge clk); src = 32'd1 << 9;
    check_irqs("R7 before claim");
    rd(ca(1), d); check("R7 claim ctx1", d, 32'd9); clm_m[9] = 1;
    #1; check("R7 ctx0 irq", 32'(irq[0]), 32'd0);
    rd(ca(0), d); check("R7 ctx0 claim", d, 32'd0);

    // R9 ignored completions
    wr(ca(0), 32'd0);
    wr(ca(0), 32'd7);
    wr(ca(0), 32'd40);
    wr(ca(0), 32'h0100_0009);
    #1; check("R9 irq stays low", 32'(irq), 32'd0);
    rd(ca(0), d); check("R9 claim stays empty", d, 32'd0);

    // R8 completion re-delivers a still-high line
    wr(ca(0), 32'd9); clm_m[9] = 0;
    #1; check("R8 redelivery", 32'(irq), 32'd3);
    rd(ca(0), d); check("R8 reclaim", d, 32'd9); clm_m[9] = 1;
    wr(ca(0), 32'd9); clm_m[9] = 0;
    @(negedge clk); src = '0;
    check_irqs("R5 lines low");

    // R10 unmapped space
    rd(22'h001000, d); check("R10 gap read", d, 32'd0);
    wr(ea(2, 0), 32'hFFFF_FFFF);
    rd(ea(2, 0), d); check("R10 absent ctx enable", d, 32'd0);
    rd(ea(0, 1), d); check("R10 absent enable word", d, 32'd0);
    rd(ta(2), d);    check("R10 absent ctx page", d, 32'd0);
    rd(ta(0) + 22'h8, d); check("R10 unused offset", d, 32'd0);
    wr(22'h000006, 32'd7);
    rd(pa(1), d); check("R10 unaligned write ignored", d, 32'(prio_m[1]));
    rd(22'h000005, d); check("R10 unaligned read", d, 32'd0);
    rd(ea(0, 0), d); check("R10 ctx0 enable intact", d, 32'hFFFF_FFFE);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule